// File: doc/BRIEF.md
# Microprogram Sequencer with Dispatch Fork and Return Stack

This block chooses the microcode address for a microcoded controller, one address per clock. Each microword carries three things: a 4-bit selector that picks one bit out of a 16-entry condition vector, a then-target and an else-target. Each target is a kind code plus an address. When the chosen condition bit is 1 the then-target is applied, and when it is 0 the else-target is applied. The kinds are: step to the following address, hold the current address, jump or call to an absolute address, return, and fork. A jump and a call behave the same way: both save the current address on a small hardware return stack. A fork takes its address from a dispatch table that is indexed by the instruction register.

The block exports both the registered microprogram counter and the address that the counter will take at the next edge, so that a debug display can show them. A microword whose two targets are both "step" works as a one-cycle wait. Chaining several of them lets a slow datapath settle before a condition is tested. The microcode store and the datapath sit outside this block.

Top module: `microseq`

## Requirements
- R1: A synchronous active-high `rst` sets `upc_o` to 0 at the next rising edge and empties the return stack. Reset takes priority over any target presented in the same cycle.
- R2: Selector value 0 always reads as true and selector value 15 always reads as false. Selector value k in 1..14 reads `cond_in[k]`. Bits 0 and 15 of `cond_in` have no effect.
- R3: When the selected bit is 1 the then-kind and then-address are used. When it is 0 the else-kind and else-address are used.
- R4: Kind code 0 (step) gives `upc_o + 1`, which wraps modulo 2^UA_W. Codes 6 and 7 behave the same as step. A microword with step on both sides advances by one address whatever the condition.
- R5: Kind code 1 (hold) leaves the address unchanged, so the same microword runs again.
- R6: Kind codes 2 (jump) and 3 (call) both load the target address and push the current `upc_o` onto the return stack.
- R7: Kind code 4 (return) pops the stack and resumes at the saved address plus one. A return on an empty stack goes to address 0.
- R8: The stack holds STACK_DEPTH entries (default 4). A push onto a full stack discards the oldest entry.
- R9: Kind code 5 (fork) loads the dispatch entry for `ir_in`. With the default parameters, an `ir_in` below 0x20 gives `ir_in[5:0]` and any other value gives 40.
- R10: `next_o` is the value that `upc_o` takes at the following rising edge, and `upc_o` is a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cond_in | input | 16 | Condition vector (bits 0 and 15 are replaced by constants) |
| ir_in | input | IR_W | Instruction register, index into the dispatch table |
| cond_sel | input | 4 | Condition selector field of the microword |
| then_kind | input | 3 | Target kind used when the condition is true |
| then_addr | input | UA_W | Target address used when the condition is true |
| else_kind | input | 3 | Target kind used when the condition is false |
| else_addr | input | UA_W | Target address used when the condition is false |
| upc_o | output | UA_W | Current microprogram counter |
| next_o | output | UA_W | Address to be loaded at the next edge |

## Verification
Reset and a stack push can fall in the same cycle: a call microword is presented while `rst` is high. The bench first makes a call so that the stack is not empty. It then asserts reset while a call to 33 is on the microword fields, and finally issues a return. The run passes only if `upc_o` is 0 after the reset edge and the return also lands on 0. Landing on 0 proves that the push was suppressed and the stack was emptied. If the saved entry had survived, the return would resume at 1. The push that overflows a full stack is also judged through later returns: after five nested calls, four returns land on the four newest saved addresses plus one, and the fifth return lands on 0.

// File: rtl/microseq_pkg.sv
package microseq_pkg;
  localparam int COND_N = 16;
  localparam int SEL_W  = $clog2(COND_N);
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    TK_STEP = 3'd0,
    TK_HOLD = 3'd1,
    TK_JUMP = 3'd2,
    TK_CALL = 3'd3,
    TK_RET  = 3'd4,
    TK_FORK = 3'd5,
    TK_ALT6 = 3'd6,
    TK_ALT7 = 3'd7
  } tgt_kind_e;
endpackage

// File: rtl/microseq_cond_sel.sv
module microseq_cond_sel
  import microseq_pkg::*;
(
  input  logic [COND_N-1:0] cond_in,
  input  logic [SEL_W-1:0]  sel,
  output logic              bit_o
);
  // Lowest index is forced high, highest index is forced low.
  localparam logic [COND_N-1:0] KEEP_MASK  = {1'b0, {(COND_N-2){1'b1}}, 1'b0};
  localparam logic [COND_N-1:0] FORCE_HIGH = {{(COND_N-1){1'b0}}, 1'b1};

  logic [COND_N-1:0] eff;

  always_comb begin
    eff   = (cond_in & KEEP_MASK) | FORCE_HIGH;
    bit_o = eff[sel];
  end
endmodule

// File: rtl/microseq_map_rom.sv
module microseq_map_rom #(
  parameter int IR_W        = 7,
  parameter int UA_W        = 6,
  parameter int MAP_SPLIT   = 32,
  parameter int MAP_DEFAULT = 40
) (
  input  logic [IR_W-1:0] ir,
  output logic [UA_W-1:0] addr_o
);
  localparam int ENTRIES = 1 << IR_W;

  logic [UA_W-1:0] table_q [ENTRIES];

  // Control codes dispatch to their own routine, everything else to one handler.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    if (i < MAP_SPLIT) begin : g_direct
      assign table_q[i] = UA_W'(i);
    end else begin : g_shared
      assign table_q[i] = UA_W'(MAP_DEFAULT);
    end
  end

  assign addr_o = table_q[ir];
endmodule

// File: rtl/microseq_ret_stack.sv
module microseq_ret_stack #(
  parameter int UA_W  = 6,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic            pop,
  input  logic [UA_W-1:0] push_data,
  output logic [UA_W-1:0] top_o,
  output logic            empty_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [UA_W-1:0]  ent_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (push) begin
      // Shift down; the entry falling off the bottom is the oldest.
      ent_q[0] <= push_data;
      for (int i = 1; i < DEPTH; i++) ent_q[i] <= ent_q[i-1];
      if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end else if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) ent_q[i] <= ent_q[i+1];
      ent_q[DEPTH-1] <= '0;
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign top_o   = ent_q[0];
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/microseq.sv
module microseq
  import microseq_pkg::*;
#(
  parameter int UA_W        = 6,
  parameter int IR_W        = 7,
  parameter int STACK_DEPTH = 4,
  parameter int MAP_SPLIT   = 32,
  parameter int MAP_DEFAULT = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cond_in,
  input  logic [IR_W-1:0]   ir_in,
  input  logic [3:0]        cond_sel,
  input  logic [2:0]        then_kind,
  input  logic [UA_W-1:0]   then_addr,
  input  logic [2:0]        else_kind,
  input  logic [UA_W-1:0]   else_addr,
  output logic [UA_W-1:0]   upc_o,
  output logic [UA_W-1:0]   next_o
);
  logic            cond_bit;
  tgt_kind_e       kind;
  logic [UA_W-1:0] tgt_addr;
  logic [UA_W-1:0] map_addr;
  logic [UA_W-1:0] stk_top;
  logic            stk_empty;
  logic            do_push, do_pop;
  logic [UA_W-1:0] upc_q, nxt;

  microseq_cond_sel u_cond (
    .cond_in (cond_in),
    .sel     (cond_sel),
    .bit_o   (cond_bit)
  );

  microseq_map_rom #(
    .IR_W(IR_W), .UA_W(UA_W), .MAP_SPLIT(MAP_SPLIT), .MAP_DEFAULT(MAP_DEFAULT)
  ) u_map (
    .ir     (ir_in),
    .addr_o (map_addr)
  );

  microseq_ret_stack #(.UA_W(UA_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (do_push),
    .pop       (do_pop),
    .push_data (upc_q),
    .top_o     (stk_top),
    .empty_o   (stk_empty)
  );

  always_comb begin
    kind     = tgt_kind_e'(cond_bit ? then_kind : else_kind);
    tgt_addr = cond_bit ? then_addr : else_addr;
    do_push  = 1'b0;
    do_pop   = 1'b0;
    case (kind)
      TK_HOLD: nxt = upc_q;
      TK_JUMP, TK_CALL: begin
        nxt     = tgt_addr;
        do_push = 1'b1;
      end
      TK_RET: begin
        nxt    = stk_empty ? '0 : stk_top + 1'b1;
        do_pop = 1'b1;
      end
      TK_FORK: nxt = map_addr;
      default: nxt = upc_q + 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) upc_q <= '0;
    else     upc_q <= nxt;
  end

  assign upc_o  = upc_q;
  assign next_o = nxt;
endmodule

// File: rtl/microseq_chk.sv
module microseq_chk #(
  parameter int UA_W        = 6,
  parameter int IR_W        = 7,
  parameter int MAP_SPLIT   = 32,
  parameter int MAP_DEFAULT = 40
) (
  input logic            clk,
  input logic            rst,
  input logic [IR_W-1:0] ir_in,
  input logic [3:0]      cond_sel,
  input logic [2:0]      then_kind,
  input logic [UA_W-1:0] then_addr,
  input logic [2:0]      else_kind,
  input logic [UA_W-1:0] upc_o,
  input logic [UA_W-1:0] next_o
);
  logic [UA_W-1:0] exp_map;
  assign exp_map = (int'(ir_in) < MAP_SPLIT) ? UA_W'(ir_in) : UA_W'(MAP_DEFAULT);

  a_r1_reset_zero: assert property (@(posedge clk) rst |=> upc_o == '0);

  a_r10_next_follows: assert property (@(posedge clk) disable iff (rst)
    !rst |=> upc_o == $past(next_o));

  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 4'd0 && then_kind == 3'd0) |-> next_o == UA_W'(upc_o + 1'b1));

  a_r5_hold_on_false: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 4'd15 && else_kind == 3'd1) |-> next_o == upc_o);

  a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 4'd0 && (then_kind == 3'd2 || then_kind == 3'd3)) |-> next_o == then_addr);

  a_r9_fork_lookup: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 4'd0 && then_kind == 3'd5) |-> next_o == exp_map);
endmodule

bind microseq microseq_chk #(
  .UA_W(UA_W), .IR_W(IR_W), .MAP_SPLIT(MAP_SPLIT), .MAP_DEFAULT(MAP_DEFAULT)
) chk_i (
  .clk(clk), .rst(rst), .ir_in(ir_in), .cond_sel(cond_sel),
  .then_kind(then_kind), .then_addr(then_addr), .else_kind(else_kind),
  .upc_o(upc_o), .next_o(next_o)
);

// File: tb/microseq_tb_top.sv
module microseq_tb_top;
  localparam int UA_W = 6;
  localparam int IR_W = 7;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [15:0]     cond_in = '0;
  logic [IR_W-1:0] ir_in = '0;
  logic [3:0]      cond_sel = '0;
  logic [2:0]      then_kind = '0, else_kind = '0;
  logic [UA_W-1:0] then_addr = '0, else_addr = '0;
  logic [UA_W-1:0] upc_o, next_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  microseq #(.UA_W(UA_W), .IR_W(IR_W)) dut_i (
    .clk(clk), .rst(rst), .cond_in(cond_in), .ir_in(ir_in), .cond_sel(cond_sel),
    .then_kind(then_kind), .then_addr(then_addr), .else_kind(else_kind),
    .else_addr(else_addr), .upc_o(upc_o), .next_o(next_o)
  );

  // Kind codes: 0 step, 1 hold, 2 jump, 3 call, 4 return, 5 fork, 6/7 step.
  typedef struct packed {
    logic [3:0]  sel;
    logic [15:0] cin;
    logic [6:0]  ir;
    logic [2:0]  tk;
    logic [5:0]  ta;
    logic [2:0]  ek;
    logic [5:0]  ea;
    logic [5:0]  exn;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{4'd0,  16'h0000, 7'h00, 3'd0, 6'd0,  3'd1, 6'd0,  6'd1,  4'd4}, // R4 step
    '{4'd15, 16'hFFFF, 7'h00, 3'd2, 6'd50, 3'd1, 6'd0,  6'd1,  4'd5}, // R5 hold, R2 false
    '{4'd3,  16'h0008, 7'h00, 3'd2, 6'd20, 3'd0, 6'd0,  6'd20, 4'd6}, // R6 jump pushes 1
    '{4'd3,  16'hFFF7, 7'h00, 3'd0, 6'd0,  3'd3, 6'd30, 6'd30, 4'd3}, // R3 else call
    '{4'd0,  16'h0000, 7'h00, 3'd4, 6'd0,  3'd0, 6'd0,  6'd21, 4'd7}, // R7 return 20+1
    '{4'd15, 16'h0000, 7'h00, 3'd0, 6'd0,  3'd4, 6'd0,  6'd2,  4'd7}, // R7 return 1+1
    '{4'd0,  16'h0000, 7'h00, 3'd4, 6'd0,  3'd0, 6'd0,  6'd0,  4'd7}, // R7 empty -> 0
    '{4'd0,  16'h0000, 7'h05, 3'd5, 6'd0,  3'd0, 6'd0,  6'd5,  4'd9}, // R9 fork low code
    '{4'd15, 16'hFFFF, 7'h41, 3'd0, 6'd0,  3'd5, 6'd0,  6'd40, 4'd2}, // R2 bit15 ignored
    '{4'd7,  16'h0080, 7'h00, 3'd6, 6'd0,  3'd2, 6'd0,  6'd41, 4'd4}, // R4 code 6
    '{4'd7,  16'hFF7F, 7'h00, 3'd2, 6'd0,  3'd7, 6'd0,  6'd42, 4'd4}, // R4 code 7
    '{4'd0,  16'h0000, 7'h00, 3'd2, 6'd63, 3'd0, 6'd0,  6'd63, 4'd6}, // R6 jump pushes 42
    '{4'd0,  16'h0000, 7'h00, 3'd0, 6'd0,  3'd0, 6'd0,  6'd0,  4'd4}, // R4 wrap
    '{4'd9,  16'h0200, 7'h00, 3'd0, 6'd0,  3'd0, 6'd0,  6'd1,  4'd4}, // R4 wait, true
    '{4'd9,  16'h0000, 7'h00, 3'd0, 6'd0,  3'd0, 6'd0,  6'd2,  4'd4}, // R4 wait, false
    '{4'd0,  16'h0000, 7'h1F, 3'd5, 6'd0,  3'd0, 6'd0,  6'd31, 4'd9}, // R9 fork edge code
    '{4'd0,  16'h0000, 7'h00, 3'd4, 6'd0,  3'd0, 6'd0,  6'd43, 4'd7}  // R7 return 42+1
  };

  task automatic chk(input string tag, input logic [UA_W-1:0] act, input logic [UA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] s, input logic [15:0] c, input logic [IR_W-1:0] i,
                       input logic [2:0] tk, input logic [UA_W-1:0] ta,
                       input logic [2:0] ek, input logic [UA_W-1:0] ea);
    cond_sel = s; cond_in = c; ir_in = i;
    then_kind = tk; then_addr = ta; else_kind = ek; else_addr = ea;
  endtask

  // Present a microword at the falling edge, check next_o, then upc_o after the edge.
  task automatic step_chk(input string tag, input logic [UA_W-1:0] exp);
    #1 chk({tag, " next_o"}, next_o, exp);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " upc_o"}, upc_o, exp);
  endtask

  task automatic call_to(input logic [UA_W-1:0] a);
    drive(4'd0, 16'h0, '0, 3'd3, a, 3'd0, '0);
    step_chk("R6 call", a);
  endtask

  task automatic ret_to(input logic [UA_W-1:0] a);
    drive(4'd0, 16'h0, '0, 3'd4, '0, 3'd0, '0);
    step_chk("R8 return", a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", upc_o, '0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k].sel, VEC[k].cin, VEC[k].ir, VEC[k].tk, VEC[k].ta, VEC[k].ek, VEC[k].ea);
      step_chk($sformatf("R%0d vector %0d", VEC[k].tag, k), VEC[k].exn);
    end

    // R8: five nested calls into a four-deep stack drop the first saved address (43).
    call_to(6'd10);
    call_to(6'd20);
    call_to(6'd30);
    call_to(6'd40);
    call_to(6'd50);
    ret_to(6'd41);
    ret_to(6'd31);
    ret_to(6'd21);
    ret_to(6'd11);
    ret_to(6'd0);

    // R1: reset in the same cycle as a call; the push must not survive.
    call_to(6'd12);
    rst = 1'b1;
    drive(4'd0, 16'h0, '0, 3'd3, 6'd33, 3'd0, '0);
    @(posedge clk);
    @(negedge clk);
    chk("R1 reset beats call", upc_o, '0);
    rst = 1'b0;
    drive(4'd0, 16'h0, '0, 3'd4, '0, 3'd0, '0);
    step_chk("R1 stack emptied by reset", 6'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule